// File: doc/BRIEF.md
# Streaming Systolic Matrix Multiply-Accumulate

This block computes Y = Kᵀ·X + A on streamed matrices. Rows of K (ROWS lanes) and rows of X (COLS lanes) arrive together, one row pair per beat, on two AXI4-Stream slave ports. A packet ends with the beat that has `k_last` set, and the number of beats in a packet is the reduction depth. A ROWS×COLS grid of signed multiply-accumulate cells forms every product sum. Each cell has a pipelined multiplier (MUL_LAT stages) and a one-cycle accumulator. Operands are skewed at the grid edges, so each cell sees its pair one step later per row and per column. The per-beat valid and last markers never fan out across the grid. They hop from cell to cell with the operand wavefront.

When the bottom-right cell closes its sum, the whole result matrix is copied into an output shift chain. The chain releases one column per output beat, column 0 first, and shifts right on every accepted beat, with empty slots entering from the left. A third slave stream supplies one bias column per output beat, and that column is added on the way out. If the chain still holds an undrained result when the next result is ready, the grid and the input ports freeze together.

Top module: `sysmm_core`

## Requirements
- R1: Output beat j of a packet carries column j of Kᵀ·X plus the bias beat consumed with it, modulo 2^ACC_W. k lane r is `k_data[r*DATA_W +: DATA_W]`, x lane c is `x_data[c*DATA_W +: DATA_W]`, and bias and result lane r are `[r*ACC_W +: ACC_W]`. Operands are signed two's complement.
- R2: Each packet yields exactly COLS output beats, in packet order. `y_last` is high on the COLS-th beat and on no other beat.
- R3: A k beat is accepted in exactly the cycles in which an x beat is accepted.
- R4: One bias beat is accepted per accepted output beat and in no other cycle. `y_valid` is never high while `a_valid` is low.
- R5: While `y_valid` is high and `y_ready` is low, `y_valid`, `y_data` and `y_last` hold their values in the next cycle.
- R6: During synchronous active-low reset and right after it, `y_valid` and `a_ready` are low.
- R7: A k beat carrying last is accepted no sooner than ROWS+COLS-1 cycles after the previous accepted last beat.
- R8: Single-beat packets, 20-beat packets and full-scale operands (−128·−128 and 127·−128 with 8-bit data) give results that match R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| k_valid | input | 1 | K row beat valid |
| k_ready | output | 1 | K row beat accepted |
| k_data | input | ROWS*DATA_W | One row of K, lane r = column r of K |
| k_last | input | 1 | Final beat of the packet |
| x_valid | input | 1 | X row beat valid |
| x_ready | output | 1 | X row beat accepted |
| x_data | input | COLS*DATA_W | One row of X |
| a_valid | input | 1 | Bias column valid |
| a_ready | output | 1 | Bias column accepted |
| a_data | input | ROWS*ACC_W | Bias column for the current output beat |
| y_valid | output | 1 | Result column valid |
| y_ready | input | 1 | Downstream accepts the result column |
| y_data | output | ROWS*ACC_W | Result column |
| y_last | output | 1 | Final column of a result matrix |

## Verification
Random signed operands over packets of mixed depth show that the skewed wavefront pairs the right K and X elements, because a one-step misalignment sends the products to the wrong cells. Back-to-back single-beat packets test the last-beat holdoff and the per-packet accumulator restart. Without them, one packet's sum would leak into the next or overwrite a result that the chain has not yet loaded. Full-scale operands over 20-beat packets test sign extension and accumulator width. Random input gaps and bursts of downstream stall make the chain fill while a second result completes, which tests the freeze of grid and inputs, as well as output stability.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;

   // Enabled MAC steps that a last beat must wait after the previous one.
   function automatic int holdoff_steps(input int rows, input int cols);
      return rows + cols - 2;
   endfunction

   function automatic int ctr_width(input int maxval);
      return (maxval < 1) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/sysmm_delay.sv
module sysmm_delay #(
   parameter int W = 8,
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (N < 1) begin : g_bad_n
      $error("sysmm_delay: N must be at least 1");
   end

   logic [W-1:0] stg [N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) stg[i] <= '0;
      end else if (en) begin
         stg[0] <= d;
         for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[N-1];

endmodule

// File: rtl/sysmm_pe.sv
module sysmm_pe #(
   parameter int DATA_W  = 8,
   parameter int ACC_W   = 24,
   parameter int MUL_LAT = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic signed [DATA_W-1:0] k_in,
   input  logic signed [DATA_W-1:0] x_in,
   input  logic                     v_in,
   input  logic                     l_in,
   output logic signed [DATA_W-1:0] k_out,
   output logic signed [DATA_W-1:0] x_out,
   output logic                     v_out,
   output logic                     l_out,
   output logic                     done_out,
   output logic        [ACC_W-1:0]  res_out
);

   localparam int PW = 2 * DATA_W;

   logic signed [PW-1:0]    prod;
   logic signed [PW-1:0]    pp [MUL_LAT];
   logic [MUL_LAT-1:0]      pv, pl;
   logic signed [ACC_W-1:0] acc, p_ext, sum;
   logic                    fresh;

   assign prod = PW'(k_in) * PW'(x_in);

   // operand and marker forwarding to the right and downward neighbours
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         k_out <= '0;
         x_out <= '0;
         v_out <= 1'b0;
         l_out <= 1'b0;
      end else if (en) begin
         k_out <= k_in;
         x_out <= x_in;
         v_out <= v_in;
         l_out <= l_in;
      end
   end

   // multiplier pipeline with marker shadows
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MUL_LAT; i++) pp[i] <= '0;
         pv <= '0;
         pl <= '0;
      end else if (en) begin
         pp[0] <= prod;
         pv[0] <= v_in;
         pl[0] <= l_in;
         for (int i = 1; i < MUL_LAT; i++) begin
            pp[i] <= pp[i-1];
            pv[i] <= pv[i-1];
            pl[i] <= pl[i-1];
         end
      end
   end

   assign p_ext = ACC_W'(pp[MUL_LAT-1]);
   assign sum   = (fresh ? '0 : acc) + p_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc     <= '0;
         fresh   <= 1'b1;
         res_out <= '0;
      end else if (en && pv[MUL_LAT-1]) begin
         if (pl[MUL_LAT-1]) begin
            res_out <= sum;
            acc     <= '0;
            fresh   <= 1'b1;
         end else begin
            acc     <= sum;
            fresh   <= 1'b0;
         end
      end
   end

   assign done_out = pv[MUL_LAT-1] && pl[MUL_LAT-1];

endmodule

// File: rtl/sysmm_core.sv
module sysmm_core
   import sysmm_pkg::*;
#(
   parameter int ROWS    = 3,
   parameter int COLS    = 4,
   parameter int DATA_W  = 8,
   parameter int ACC_W   = 24,
   parameter int MUL_LAT = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    k_valid,
   output logic                    k_ready,
   input  logic [ROWS*DATA_W-1:0]  k_data,
   input  logic                    k_last,
   input  logic                    x_valid,
   output logic                    x_ready,
   input  logic [COLS*DATA_W-1:0]  x_data,
   input  logic                    a_valid,
   output logic                    a_ready,
   input  logic [ROWS*ACC_W-1:0]   a_data,
   output logic                    y_valid,
   input  logic                    y_ready,
   output logic [ROWS*ACC_W-1:0]   y_data,
   output logic                    y_last
);

   localparam int HOLD = holdoff_steps(ROWS, COLS);
   localparam int CW   = ctr_width(HOLD);

   if (ROWS < 1 || COLS < 1) begin : g_bad_dim
      $error("sysmm_core: ROWS and COLS must be positive");
   end
   if (ACC_W < 2 * DATA_W) begin : g_bad_acc
      $error("sysmm_core: ACC_W must hold a full product");
   end
   if (MUL_LAT < 1) begin : g_bad_lat
      $error("sysmm_core: MUL_LAT must be at least 1");
   end

   logic          en_mac, gate, s_fire, s_lastfire;
   logic          ld_q, chain_free, out_fire;
   logic [CW-1:0] cool;

   logic [DATA_W-1:0] k_sk [ROWS];
   logic [DATA_W-1:0] x_sk [COLS];
   logic [DATA_W-1:0] kh   [ROWS][COLS];
   logic [DATA_W-1:0] xh   [ROWS][COLS];
   logic              vh   [ROWS][COLS];
   logic              lh   [ROWS][COLS];
   logic              dn   [ROWS][COLS];
   logic [ACC_W-1:0]  res  [ROWS][COLS];

   logic [ROWS*ACC_W-1:0] slot [COLS];
   logic [COLS-1:0]       occ;

   // ---------------- input join and holdoff ----------------
   assign en_mac     = !ld_q || chain_free;
   assign gate       = en_mac && !(k_last && (cool != '0));
   assign k_ready    = x_valid && gate;
   assign x_ready    = k_valid && gate;
   assign s_fire     = k_valid && x_valid && gate;
   assign s_lastfire = s_fire && k_last;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cool <= '0;
      else if (s_lastfire)
         cool <= CW'(HOLD);
      else if (en_mac && cool != '0)
         cool <= cool - CW'(1);
   end

   // ---------------- edge skew ----------------
   for (genvar r = 0; r < ROWS; r++) begin : g_kskew
      if (r == 0) begin : g_direct
         assign k_sk[r] = k_data[0 +: DATA_W];
      end else begin : g_delay
         sysmm_delay #(.W(DATA_W), .N(r)) u_dly (
            .clk(clk), .rst_n(rst_n), .en(en_mac),
            .d(k_data[r*DATA_W +: DATA_W]), .q(k_sk[r]));
      end
   end

   for (genvar c = 0; c < COLS; c++) begin : g_xskew
      if (c == 0) begin : g_direct
         assign x_sk[c] = x_data[0 +: DATA_W];
      end else begin : g_delay
         sysmm_delay #(.W(DATA_W), .N(c)) u_dly (
            .clk(clk), .rst_n(rst_n), .en(en_mac),
            .d(x_data[c*DATA_W +: DATA_W]), .q(x_sk[c]));
      end
   end

   // ---------------- MAC grid, markers hop with the wavefront ----------------
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         logic [DATA_W-1:0] ki, xi;
         logic              vi, li;

         if (c == 0) begin : g_kedge
            assign ki = k_sk[r];
         end else begin : g_kpass
            assign ki = kh[r][c-1];
         end

         if (r == 0) begin : g_xedge
            assign xi = x_sk[c];
         end else begin : g_xpass
            assign xi = xh[r-1][c];
         end

         if (c > 0) begin : g_mleft
            assign vi = vh[r][c-1];
            assign li = lh[r][c-1];
         end else if (r > 0) begin : g_mup
            assign vi = vh[r-1][0];
            assign li = lh[r-1][0];
         end else begin : g_morigin
            assign vi = s_fire;
            assign li = s_lastfire;
         end

         sysmm_pe #(.DATA_W(DATA_W), .ACC_W(ACC_W), .MUL_LAT(MUL_LAT)) u_pe (
            .clk(clk), .rst_n(rst_n), .en(en_mac),
            .k_in(ki), .x_in(xi), .v_in(vi), .l_in(li),
            .k_out(kh[r][c]), .x_out(xh[r][c]),
            .v_out(vh[r][c]), .l_out(lh[r][c]),
            .done_out(dn[r][c]), .res_out(res[r][c]));
      end
   end

   // ---------------- result load request ----------------
   always_ff @(posedge clk) begin
      if (!rst_n)
         ld_q <= 1'b0;
      else if (en_mac && dn[ROWS-1][COLS-1])
         ld_q <= 1'b1;
      else if (chain_free)
         ld_q <= 1'b0;
   end

   // ---------------- output shift chain ----------------
   assign y_last     = (occ == (COLS'(1) << (COLS - 1)));
   assign y_valid    = occ[COLS-1] && a_valid;
   assign a_ready    = occ[COLS-1] && y_ready;
   assign out_fire   = y_valid && y_ready;
   assign chain_free = !occ[COLS-1] || (out_fire && y_last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ <= '0;
         for (int s = 0; s < COLS; s++) slot[s] <= '0;
      end else if (ld_q && chain_free) begin
         occ <= '1;
         for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++)
               slot[COLS-1-c][r*ACC_W +: ACC_W] <= res[r][c];
      end else if (out_fire) begin
         occ     <= occ << 1;
         slot[0] <= '0;
         for (int s = 1; s < COLS; s++) slot[s] <= slot[s-1];
      end
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_bias
      assign y_data[r*ACC_W +: ACC_W] =
         slot[COLS-1][r*ACC_W +: ACC_W] + a_data[r*ACC_W +: ACC_W];
   end

endmodule

// File: rtl/sysmm_core_chk.sv
module sysmm_core_chk #(
   parameter int ROWS    = 3,
   parameter int COLS    = 4,
   parameter int ACC_W   = 24
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   k_valid,
   input logic                   k_ready,
   input logic                   k_last,
   input logic                   x_valid,
   input logic                   x_ready,
   input logic                   a_valid,
   input logic                   a_ready,
   input logic                   y_valid,
   input logic                   y_ready,
   input logic [ROWS*ACC_W-1:0]  y_data,
   input logic                   y_last
);

   localparam int GAP = ROWS + COLS - 1;

   logic [15:0] since;
   logic        seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since <= '0;
         seen  <= 1'b0;
      end else if (k_valid && k_ready && k_last) begin
         since <= 16'd1;
         seen  <= 1'b1;
      end else if (since < 16'(GAP)) begin
         since <= since + 16'd1;
      end
   end

   // R3
   join_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (k_valid && k_ready) == (x_valid && x_ready));

   // R4
   bias_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid && a_ready) == (y_valid && y_ready));

   // R4
   bias_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid |-> a_valid);

   // R5
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (y_valid && !y_ready) |=> (y_valid && $stable(y_data) && $stable(y_last)));

   // R7
   last_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (k_valid && k_ready && k_last && seen) |-> (since >= 16'(GAP)));

endmodule

bind sysmm_core sysmm_core_chk #(.ROWS(ROWS), .COLS(COLS), .ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .k_valid(k_valid), .k_ready(k_ready), .k_last(k_last),
   .x_valid(x_valid), .x_ready(x_ready),
   .a_valid(a_valid), .a_ready(a_ready),
   .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data), .y_last(y_last));

// File: tb/tb_sysmm_core.sv
`timescale 1ns/1ps
module tb_sysmm_core;

   localparam int ROWS = 3;
   localparam int COLS = 4;
   localparam int DW   = 8;
   localparam int AW   = 24;
   localparam int ML   = 2;
   localparam int GAP  = ROWS + COLS - 1;
   localparam int LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n;
   logic k_valid, k_ready, k_last;
   logic [ROWS*DW-1:0] k_data;
   logic x_valid, x_ready;
   logic [COLS*DW-1:0] x_data;
   logic a_valid, a_ready;
   logic [ROWS*AW-1:0] a_data;
   logic y_valid, y_ready, y_last;
   logic [ROWS*AW-1:0] y_data;

   always #2 clk = ~clk;

   sysmm_core #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DW), .ACC_W(AW), .MUL_LAT(ML)) dut (
      .clk(clk), .rst_n(rst_n),
      .k_valid(k_valid), .k_ready(k_ready), .k_data(k_data), .k_last(k_last),
      .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data),
      .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
      .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data), .y_last(y_last));

   logic [ROWS*DW-1:0] kq_d [$];
   bit                 kq_l [$];
   bit                 kq_s [$];
   logic [COLS*DW-1:0] xq_d [$];
   bit                 xq_s [$];
   logic [ROWS*AW-1:0] aq_d [$];
   bit                 aq_s [$];
   logic [ROWS*AW-1:0] eq_d [$];
   bit                 eq_l [$];
   string              eq_t [$];

   int  n_vec = 0, n_bad = 0, n_out = 0, cyc = 0, last_c = 0;
   bit  go = 0, seen_last = 0, k_done = 0, x_done = 0, a_done = 0;
   bit  stall_prev = 0;
   logic [ROWS*AW-1:0] prev_d;
   logic               prev_l;

   task automatic chk(input bit ok, input string req,
                      input logic [127:0] act, input logic [127:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Reference model: build inputs and the expected output beats per packet.
   // mode 0 random, 1 all -128, 2 k=127 and x=-128
   task automatic gen_pkt(input int depth, input int mode, input bit st);
      int km [32][ROWS];
      int xm [32][COLS];
      logic [ROWS*DW-1:0] kd;
      logic [COLS*DW-1:0] xd;
      logic [ROWS*AW-1:0] ad, ed;
      string tag;
      tag = (depth == 1 || depth >= 20 || mode != 0) ? "R8 data" : "R1 data";
      for (int t = 0; t < depth; t++) begin
         for (int r = 0; r < ROWS; r++)
            km[t][r] = (mode == 1) ? -128 : (mode == 2) ? 127 : int'($signed(8'($urandom)));
         for (int c = 0; c < COLS; c++)
            xm[t][c] = (mode != 0) ? -128 : int'($signed(8'($urandom)));
         for (int r = 0; r < ROWS; r++) kd[r*DW +: DW] = DW'(km[t][r]);
         for (int c = 0; c < COLS; c++) xd[c*DW +: DW] = DW'(xm[t][c]);
         kq_d.push_back(kd); kq_l.push_back(t == depth - 1); kq_s.push_back(st);
         xq_d.push_back(xd); xq_s.push_back(st);
      end
      for (int j = 0; j < COLS; j++) begin
         for (int r = 0; r < ROWS; r++) begin
            int s;
            s = 0;
            for (int t = 0; t < depth; t++) s += km[t][r] * xm[t][j];
            ad[r*AW +: AW] = AW'($urandom);
            ed[r*AW +: AW] = AW'(s) + ad[r*AW +: AW];
         end
         aq_d.push_back(ad); aq_s.push_back(st);
         eq_d.push_back(ed); eq_l.push_back(j == COLS - 1); eq_t.push_back(tag);
      end
   endtask

   // k driver
   initial begin : drv_k
      k_valid = 0; k_last = 0; k_data = '0;
      wait (go);
      @(posedge clk); #1;
      while (kq_d.size() > 0) begin
         bit acc, st;
         k_data = kq_d.pop_front(); k_last = kq_l.pop_front(); st = kq_s.pop_front();
         k_valid = 0;
         if (st) while ($urandom % 3 == 0) begin @(posedge clk); #1; end
         k_valid = 1;
         acc = 0;
         while (!acc) begin @(negedge clk); acc = k_ready; @(posedge clk); #1; end
         k_valid = 0; k_last = 0;
      end
      k_done = 1;
   end

   // x driver
   initial begin : drv_x
      x_valid = 0; x_data = '0;
      wait (go);
      @(posedge clk); #1;
      while (xq_d.size() > 0) begin
         bit acc, st;
         x_data = xq_d.pop_front(); st = xq_s.pop_front();
         if (st) while ($urandom % 4 == 0) begin @(posedge clk); #1; end
         x_valid = 1;
         acc = 0;
         while (!acc) begin @(negedge clk); acc = x_ready; @(posedge clk); #1; end
         x_valid = 0;
      end
      x_done = 1;
   end

   // bias driver
   initial begin : drv_a
      a_valid = 0; a_data = '0;
      wait (go);
      @(posedge clk); #1;
      while (aq_d.size() > 0) begin
         bit acc, st;
         a_data = aq_d.pop_front(); st = aq_s.pop_front();
         if (st) while ($urandom % 4 == 0) begin @(posedge clk); #1; end
         a_valid = 1;
         acc = 0;
         while (!acc) begin @(negedge clk); acc = a_ready; @(posedge clk); #1; end
         a_valid = 0;
      end
      a_done = 1;
   end

   // downstream ready: free-running first, then random with stall bursts
   initial begin : drv_y
      y_ready = 0;
      wait (go);
      forever begin
         @(posedge clk); #1;
         if (n_out < 4 * COLS) y_ready = 1;
         else if ($urandom % 40 == 0) begin
            y_ready = 0;
            repeat (15) @(posedge clk);
            #1;
         end else y_ready = ($urandom % 3 != 0);
      end
   end

   // per-clock monitor against the reference queues
   always @(negedge clk) begin
      if (rst_n && go) begin
         bit kf, xf, af, yf;
         cyc++;
         kf = k_valid && k_ready;
         xf = x_valid && x_ready;
         af = a_valid && a_ready;
         yf = y_valid && y_ready;
         chk(kf == xf, "R3 joint accept", kf, xf);
         chk(af == yf, "R4 bias per beat", af, yf);
         if (y_valid) chk(a_valid, "R4 valid needs bias", a_valid, 1);
         if (stall_prev) begin
            chk(y_valid, "R5 valid held", y_valid, 1);
            chk(y_data == prev_d, "R5 data held", y_data, prev_d);
            chk(y_last == prev_l, "R5 last held", y_last, prev_l);
         end
         if (kf && k_last) begin
            if (seen_last) chk(cyc - last_c >= GAP, "R7 last holdoff", cyc - last_c, GAP);
            seen_last = 1;
            last_c = cyc;
         end
         if (yf) begin
            if (eq_d.size() == 0) chk(0, "R2 unexpected beat", y_data, 0);
            else begin
               logic [ROWS*AW-1:0] e;
               bit el;
               string tg;
               e = eq_d.pop_front(); el = eq_l.pop_front(); tg = eq_t.pop_front();
               chk(y_data == e, tg, y_data, e);
               chk(y_last == el, "R2 last marker", y_last, el);
            end
            n_out++;
         end
         stall_prev = y_valid && !y_ready;
         prev_d = y_data;
         prev_l = y_last;
      end
   end

   initial begin : main
      int wd;
      rst_n = 0;
      gen_pkt(3, 0, 0);
      gen_pkt(1, 0, 0);
      gen_pkt(1, 0, 0);
      gen_pkt(5, 1, 0);
      gen_pkt(20, 1, 1);
      gen_pkt(20, 2, 1);
      for (int i = 0; i < 3; i++) gen_pkt(1, 0, 1);
      for (int i = 0; i < 20; i++) gen_pkt(1 + int'($urandom % 12), 0, 1);

      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(y_valid == 0, "R6 valid in reset", y_valid, 0);
      chk(a_ready == 0, "R6 bias ready in reset", a_ready, 0);
      @(posedge clk); #1;
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(y_valid == 0, "R6 valid after reset", y_valid, 0);
      chk(a_ready == 0, "R6 bias ready after reset", a_ready, 0);
      go = 1;

      wd = 0;
      while (!(k_done && x_done && a_done && eq_d.size() == 0) && wd < LIMIT) begin
         @(negedge clk);
         wd++;
      end
      if (wd >= LIMIT) chk(0, "R2 watchdog expired", eq_d.size(), 0);
      repeat (20) @(negedge clk);
      chk(y_valid == 0, "R2 no extra beats", y_valid, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule